// File: doc/BRIEF.md
# Colour Palette Table with Sequenced Host Loading

This block holds a colour palette for pseudo-colour display modes. Every entry carries a red, a green and a blue intensity, each 4 bits wide. A host fills the table through two registers. The first register selects the entry number. The second register receives the colour components one after another. An internal component pointer decides which field each data access reaches. It steps red, green, blue and then moves on to the next entry, so the host can stream a run of entries after writing a single entry number.

A pixel pipeline reads the table through its own port, which is independent of the host side. It presents an 8-bit pixel value, and one clock later the block returns the stored 12-bit colour. The host can also read back components through the data register. These reads move the pointer in the same way as writes do. The entry count is a parameter, with a default of 256. An entry number at or above that count is refused.

Top module: `clut_loader`

## Requirements
- R1: During and after a synchronous active-high reset, the entry number is 0, the pointer selects red, and `pix_rgb` and `host_rdata` are both 0. Table contents are undefined until they are written.
- R2: A write with `host_sel`=0 and a value below DEPTH sets the entry number to that value and returns the pointer to red. This holds even when the previous entry is only partly loaded.
- R3: A write with `host_sel`=0 and a value at or above DEPTH is ignored. The entry number and the pointer both keep their values.
- R4: With `host_sel`=1, successive data writes store `host_wdata[3:0]` into red, then green, then blue of the current entry. Bits [7:4] are ignored.
- R5: A data write changes only the field that the pointer selects. The other two fields of that entry keep their earlier values.
- R6: After a blue access, the pointer returns to red and the entry number increments by one. After entry DEPTH-1 it wraps to 0.
- R7: One clock after `pix_idx` is sampled, `pix_rgb` presents the entry as red in [11:8], green in [7:4] and blue in [3:0]. An index at or above DEPTH returns 0.
- R8: When a host write and a pixel read address the same entry in the same cycle, the pixel read returns the value from before the write.
- R9: A read with `host_re`=1 and `host_sel`=1 loads `host_rdata` on the next clock with {4'b0, selected component}, and steps the pointer the same way a write does. If read and write are asserted together, the pointer steps once and the read returns the old value. At all other times `host_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_sel | input | 1 | 0 selects the entry-number register, 1 selects the component data register |
| host_wdata | input | 8 | Host write value |
| host_rdata | output | 8 | Component returned by a data-register read |
| pix_idx | input | 8 | Pixel-side table index |
| pix_rgb | output | 12 | Colour of the indexed entry, one cycle later |

## Verification
A stuck or misordered component pointer puts a value into the wrong field. That error appears at `pix_rgb` on the first pixel read of the entry, one clock after the read is issued. A pointer that skips its return to red after blue, or an entry number that fails to advance or wrap, corrupts the next entry in a stream. A read of that entry exposes the fault, including a read at the last entry and at entry 0. A refused entry number that is wrongly accepted redirects the next data write, so the fault appears at the next pixel read of the intended entry. Host read-back confirms the pointer position directly, one clock after each data read.

// File: rtl/clut_pkg.sv
package clut_pkg;

    localparam int COMP_W = 4;
    localparam int RGB_W  = 3 * COMP_W;

    typedef enum logic [1:0] {
        CMP_RED = 2'd0,
        CMP_GRN = 2'd1,
        CMP_BLU = 2'd2
    } comp_e;

    typedef struct packed {
        logic [COMP_W-1:0] red;
        logic [COMP_W-1:0] grn;
        logic [COMP_W-1:0] blu;
    } rgb_t;

    function automatic comp_e comp_next(input comp_e c);
        case (c)
            CMP_RED: return CMP_GRN;
            CMP_GRN: return CMP_BLU;
            default: return CMP_RED;
        endcase
    endfunction

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_re,
    input  logic              host_sel,
    input  logic [7:0]        host_wdata,
    output logic [IDX_W-1:0]  cur_idx,
    output comp_e             cur_comp,
    output logic [2:0]        fld_we,
    output logic              rd_strobe
);

    localparam logic [8:0]       DEPTH9 = 9'(DEPTH);
    localparam logic [IDX_W-1:0] LAST   = IDX_W'(DEPTH - 1);

    logic addr_wr, addr_ok, data_acc;

    assign addr_wr   = host_we & ~host_sel;
    assign addr_ok   = {1'b0, host_wdata} < DEPTH9;
    assign data_acc  = host_sel & (host_we | host_re);
    assign rd_strobe = host_sel & host_re;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_idx  <= '0;
            cur_comp <= CMP_RED;
        end else if (addr_wr && addr_ok) begin
            cur_idx  <= IDX_W'(host_wdata);
            cur_comp <= CMP_RED;
        end else if (data_acc) begin
            cur_comp <= comp_next(cur_comp);
            if (cur_comp == CMP_BLU)
                cur_idx <= (cur_idx == LAST) ? '0 : cur_idx + 1'b1;
        end
    end

    always_comb begin
        for (int c = 0; c < 3; c++)
            fld_we[c] = host_we & host_sel & (cur_comp == comp_e'(c));
    end

    // R2: an accepted entry number lands and rewinds the pointer
    a_r2_addr_load: assert property (@(posedge clk) disable iff (rst)
        addr_wr && addr_ok |=> cur_idx == $past(IDX_W'(host_wdata)) && cur_comp == CMP_RED);

    // R3: a refused entry number leaves the state alone
    a_r3_reject_keep: assert property (@(posedge clk) disable iff (rst)
        addr_wr && !addr_ok |=> cur_idx == $past(cur_idx) && cur_comp == $past(cur_comp));

    // R4: red is followed by green
    a_r4_red_to_grn: assert property (@(posedge clk) disable iff (rst)
        data_acc && cur_comp == CMP_RED |=> cur_comp == CMP_GRN);

    // R6: blue at the last entry wraps to entry 0, red
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        data_acc && cur_comp == CMP_BLU && cur_idx == LAST |=> cur_idx == '0 && cur_comp == CMP_RED);

endmodule

// File: rtl/clut_bank.sv
module clut_bank
    import clut_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [COMP_W-1:0] wr_val,
    input  logic              pix_ok,
    input  logic [IDX_W-1:0]  pix_i,
    output logic [COMP_W-1:0] pix_q,
    output logic [COMP_W-1:0] host_q
);

    logic [COMP_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_val;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pix_q <= '0;
        else
            pix_q <= pix_ok ? mem[pix_i] : '0;
    end

    assign host_q = mem[wr_idx];

endmodule

// File: rtl/clut_loader.sv
module clut_loader
    import clut_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic        host_re,
    input  logic        host_sel,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic [7:0]  pix_idx,
    output logic [11:0] pix_rgb
);

    localparam int         IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [8:0] DEPTH9 = 9'(DEPTH);

    logic [IDX_W-1:0]  cur_idx;
    comp_e             cur_comp;
    logic [2:0]        fld_we;
    logic              rd_strobe;
    logic              pix_ok;
    logic [COMP_W-1:0] pix_q  [3];
    logic [COMP_W-1:0] host_q [3];
    rgb_t              pix_word;

    assign pix_ok = {1'b0, pix_idx} < DEPTH9;

    clut_seq #(.DEPTH(DEPTH), .IDX_W(IDX_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_re    (host_re),
        .host_sel   (host_sel),
        .host_wdata (host_wdata),
        .cur_idx    (cur_idx),
        .cur_comp   (cur_comp),
        .fld_we     (fld_we),
        .rd_strobe  (rd_strobe)
    );

    for (genvar g = 0; g < 3; g++) begin : g_bank
        clut_bank #(.DEPTH(DEPTH), .IDX_W(IDX_W)) bank_i (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (fld_we[g]),
            .wr_idx (cur_idx),
            .wr_val (host_wdata[COMP_W-1:0]),
            .pix_ok (pix_ok),
            .pix_i  (IDX_W'(pix_idx)),
            .pix_q  (pix_q[g]),
            .host_q (host_q[g])
        );
    end

    always_comb begin
        pix_word.red = pix_q[CMP_RED];
        pix_word.grn = pix_q[CMP_GRN];
        pix_word.blu = pix_q[CMP_BLU];
    end
    assign pix_rgb = pix_word;

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (rd_strobe)
            host_rdata <= {4'b0, host_q[cur_comp]};
    end

    // R5: at most one field is written per cycle
    a_r5_one_field: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fld_we));

    // R9: host read data only moves on a data-register read
    a_r9_rd_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |=> $stable(host_rdata));

    // R7: out-of-range pixel index yields black
    a_r7_oor_zero: assert property (@(posedge clk) disable iff (rst)
        !pix_ok |=> pix_rgb == 12'h000);

endmodule

// File: tb/clut_loader_tb.sv
`timescale 1ns/1ps
module clut_loader_tb_top;

    localparam int DEPTH = 192;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0, host_re = 1'b0, host_sel = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [7:0]  pix_idx = '0;
    logic [11:0] pix_rgb;
    logic        pix_req = 1'b0;

    always #4 clk = ~clk;

    clut_loader #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst),
        .host_we(host_we), .host_re(host_re), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    int n_vec = 0;
    int n_bad = 0;

    logic [3:0] mr [DEPTH];
    logic [3:0] mg [DEPTH];
    logic [3:0] mb [DEPTH];
    int midx = 0;
    int mptr = 0;

    logic [11:0] pq [$];
    string       pt [$];
    logic [7:0]  hq [$];
    string       ht [$];

    task automatic step(input logic we, input logic re, input logic sel,
                        input logic [7:0] wd, input logic pr,
                        input logic [7:0] pi, input string tag);
        host_we = we; host_re = re; host_sel = sel; host_wdata = wd;
        pix_req = pr; pix_idx = pi;
        if (pr) begin
            pq.push_back((int'(pi) < DEPTH) ? {mr[pi], mg[pi], mb[pi]} : 12'h000);
            pt.push_back(tag);
        end
        if (sel && re) begin
            hq.push_back({4'b0, (mptr == 0) ? mr[midx] : (mptr == 1) ? mg[midx] : mb[midx]});
            ht.push_back(tag);
        end
        if (we && !sel) begin
            if (int'(wd) < DEPTH) begin midx = int'(wd); mptr = 0; end
        end else if (sel && (we || re)) begin
            if (we) begin
                if (mptr == 0) mr[midx] = wd[3:0];
                else if (mptr == 1) mg[midx] = wd[3:0];
                else mb[midx] = wd[3:0];
            end
            if (mptr == 2) begin
                mptr = 0;
                midx = (midx == DEPTH - 1) ? 0 : midx + 1;
            end else mptr = mptr + 1;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 8'h00, 0, 8'h00, "");
    endtask
    task automatic set_addr(input logic [7:0] a, input string tag);
        step(1, 0, 0, a, 0, 8'h00, tag);
    endtask
    task automatic wr_data(input logic [7:0] d, input string tag);
        step(1, 0, 1, d, 0, 8'h00, tag);
    endtask
    task automatic rd_data(input string tag);
        step(0, 1, 1, 8'h00, 0, 8'h00, tag);
    endtask
    task automatic pix_read(input logic [7:0] i, input string tag);
        step(0, 0, 0, 8'h00, 1, i, tag);
    endtask

    // monitor: capture requests at the edge, compare half a cycle later
    logic preq_d = 1'b0, hreq_d = 1'b0;
    always @(posedge clk) begin
        preq_d <= pix_req & ~rst;
        hreq_d <= host_re & host_sel & ~rst;
    end

    always @(negedge clk) begin
        if (preq_d) begin
            logic [11:0] e;
            string t;
            e = pq.pop_front(); t = pt.pop_front();
            n_vec++;
            if (pix_rgb !== e) begin
                n_bad++;
                $display("FAIL %s pix_rgb actual=%h expected=%h", t, pix_rgb, e);
            end
        end
        if (hreq_d) begin
            logic [7:0] e;
            string t;
            e = hq.pop_front(); t = ht.pop_front();
            n_vec++;
            if (host_rdata !== e) begin
                n_bad++;
                $display("FAIL %s host_rdata actual=%h expected=%h", t, host_rdata, e);
            end
        end
    end

    bit finished = 1'b0;

    initial begin
        for (int i = 0; i < DEPTH; i++) begin mr[i] = 0; mg[i] = 0; mb[i] = 0; end
        repeat (3) @(negedge clk);
        // R1: reset values at the outputs
        n_vec++;
        if (pix_rgb !== 12'h000) begin n_bad++; $display("FAIL R1 pix_rgb actual=%h expected=000", pix_rgb); end
        n_vec++;
        if (host_rdata !== 8'h00) begin n_bad++; $display("FAIL R1 host_rdata actual=%h expected=00", host_rdata); end
        rst = 1'b0;
        @(negedge clk);

        // R4: ordered component writes, upper nibble dropped; R6: streaming to next entry
        set_addr(8'd10, "R2");
        wr_data(8'hF1, "R4"); wr_data(8'hA2, "R4"); wr_data(8'h53, "R4");
        wr_data(8'h04, "R6"); wr_data(8'h05, "R6"); wr_data(8'h06, "R6");
        pix_read(8'd10, "R4");
        pix_read(8'd11, "R6");

        // R5: partial update keeps other fields
        set_addr(8'd10, "R5");
        wr_data(8'h09, "R5");
        pix_read(8'd10, "R5");

        // R2: abandoned entry, new address rewinds the pointer
        set_addr(8'd20, "R2");
        wr_data(8'h01, "R2"); wr_data(8'h02, "R2"); wr_data(8'h03, "R2");
        set_addr(8'd20, "R2");
        wr_data(8'h07, "R2"); wr_data(8'h08, "R2");
        set_addr(8'd21, "R2");
        wr_data(8'h0A, "R2"); wr_data(8'h0B, "R2"); wr_data(8'h0C, "R2");
        pix_read(8'd20, "R2");
        pix_read(8'd21, "R2");

        // R6: wrap from the last entry to entry 0
        set_addr(8'(DEPTH - 1), "R6");
        wr_data(8'h0D, "R6"); wr_data(8'h0E, "R6"); wr_data(8'h0F, "R6");
        wr_data(8'h03, "R6"); wr_data(8'h06, "R6"); wr_data(8'h09, "R6");
        pix_read(8'(DEPTH - 1), "R6");
        pix_read(8'd0, "R6");

        // R3: refused entry number leaves index and pointer unchanged
        set_addr(8'd5, "R3");
        wr_data(8'h0E, "R3");
        set_addr(8'd200, "R3");
        wr_data(8'h0D, "R3"); wr_data(8'h0C, "R3");
        wr_data(8'h0F, "R3"); wr_data(8'h01, "R3"); wr_data(8'h02, "R3");
        pix_read(8'd5, "R3");
        pix_read(8'd6, "R3");

        // R8: same-cycle write and pixel read return the old value
        set_addr(8'd30, "R8");
        wr_data(8'h01, "R8"); wr_data(8'h01, "R8"); wr_data(8'h01, "R8");
        set_addr(8'd30, "R8");
        step(1, 0, 1, 8'h02, 1, 8'd30, "R8");
        pix_read(8'd30, "R8");

        // R9: host read-back steps the pointer across entries
        set_addr(8'd10, "R9");
        rd_data("R9"); rd_data("R9"); rd_data("R9"); rd_data("R9");
        wr_data(8'h07, "R9");
        pix_read(8'd11, "R9");
        // R9: read and write together, old value returned, single step
        set_addr(8'd20, "R9");
        step(1, 1, 1, 8'h04, 0, 8'h00, "R9");
        rd_data("R9");
        pix_read(8'd20, "R9");

        // R7: out-of-range pixel index, then back-to-back reads
        pix_read(8'd250, "R7");
        pix_read(8'd21, "R7");
        pix_read(8'd0, "R7");
        idle(); idle();

        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule